// File: doc/BRIEF.md
# E3 receive payload output interface

This block sits after an E3 receive framer. It hands the recovered frame contents to the terminal equipment. Each receive clock brings in one bit, together with a marker that flags the first bit of a frame. The block tracks where each bit falls inside the 1536-bit frame, and it marks the overhead positions of the four-sub-frame E3 structure. All results leave through registers that update on the rising clock edge. The consumer samples them on that same edge.

A mode input chooses the form of the output. In serial mode, every bit leaves on its own line. A frame strobe marks the first bit of each frame, and an overhead flag marks each bit that is not payload. In nibble mode, four consecutive bits leave as one 4-bit word, with the first bit in the most significant position. A one-cycle enable marks each word, and the strobe and the overhead flag refer to the whole word. With these outputs the consumer can discard overhead without keeping its own frame counter.

Top module: `e3rx_payload_out`

## Requirements
- R1: While reset is low, and after reset until the first frame marker, every output is low: ser_data, frm_strobe, ovh_flag, nib_en and nib_data.
- R2: In serial mode, once the block has synchronised, ser_data in the cycle after a bit is presented equals that bit. This is one register stage of delay.
- R3: In serial mode, frm_strobe is high in exactly the output cycle that carries frame position 0. Position 0 is the bit presented with rx_sof, or the bit that follows position 1535.
- R4: ovh_flag is high for the bits at frame positions 0 to 11, 384 to 387, 768 to 771 and 1152 to 1155, and for no other position. In serial mode this applies to each bit.
- R5: Without a marker, the position count wraps from 1535 to 0 and raises the frame strobe again. A marker in the middle of a frame restarts the count at 0 on the bit it accompanies.
- R6: In nibble mode, after the bit at a position p with p mod 4 equal to 3, nib_en is high for one cycle. In that cycle, nib_data holds the bits of positions p-3 to p, with position p-3 in bit 3 and position p in bit 0. At all other times nib_en is low and nib_data is zero.
- R7: In nibble mode, frm_strobe and ovh_flag are high only together with nib_en. frm_strobe is high when the word holds position 0. ovh_flag is high when any of the word's four positions is overhead.
- R8: The mode input (0 for serial, 1 for nibble) is sampled with each bit. Bits presented in nibble mode produce a low ser_data. Bits presented in serial mode produce a low nib_en and a zero nib_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; all outputs update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Recovered receive bit from the framer |
| rx_sof | input | 1 | High with the first bit of a frame |
| mode_nibble | input | 1 | 0 selects serial output, 1 selects nibble output |
| ser_data | output | 1 | Serial output bit |
| frm_strobe | output | 1 | Frame boundary strobe |
| ovh_flag | output | 1 | Overhead marker for the current bit or word |
| nib_data | output | 4 | Packed word, first bit in the most significant position |
| nib_en | output | 1 | One-cycle enable for nib_data |

## Verification
The hardest case to produce from the ports is a nibble that is cut short. This happens when a frame marker arrives while a word is partly assembled, or when the mode changes in the middle of a word. Either way, a stale partial word must not leak out. To reach it, the stimulus places a marker at an odd offset into a nibble-mode frame, and it toggles the mode in the middle of a frame. The bench's own position model then predicts the first complete word after the disturbance. It also runs two full frames without a marker to reach the wrap from 1535 to 0, and it applies a reset in the middle of the stream.

// File: rtl/e3rx_pkg.sv
// Package: shared constants and types for the E3 receive payload output block.
// Assumes: the frame geometry defaults describe the four-sub-frame E3 structure.
package e3rx_pkg;

    // Default frame geometry, in bits
    localparam int E3_FRAME_BITS = 1536;
    localparam int E3_SUB_BITS   = 384;
    localparam int E3_FAW_BITS   = 12;
    localparam int E3_JC_BITS    = 4;
    localparam int E3_NIB_W      = 4;

    // Output mode encoding on mode_nibble
    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_NIBBLE = 1'b1
    } e3rx_mode_e;

endpackage

// File: rtl/e3rx_frame_pos.sv
// Module: frame position tracker.
// Gives the frame position of the bit presented this cycle. The position is 0
// when the bit comes with the frame marker. Otherwise it is the previous
// position plus one, wrapping at the end of the frame. The module also says
// whether the position is valid (a marker has been seen since reset) and
// whether it is an overhead position.
// Assumes: FRAME_BITS is a whole number of SUB_BITS sub-frames.
module e3rx_frame_pos #(
    parameter int FRAME_BITS = e3rx_pkg::E3_FRAME_BITS,
    parameter int SUB_BITS   = e3rx_pkg::E3_SUB_BITS,
    parameter int FAW_BITS   = e3rx_pkg::E3_FAW_BITS,
    parameter int JC_BITS    = e3rx_pkg::E3_JC_BITS,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    output logic [POS_W-1:0] pos,
    output logic             pos_vld,
    output logic             pos_ovh
);
    localparam int               N_SUB = FRAME_BITS / SUB_BITS;
    localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] nxt_q;
    logic             sync_q;
    logic [N_SUB-1:0] jc_hit;

    // Current position: forced to 0 by the marker, otherwise the stored successor
    assign pos     = sof ? '0 : nxt_q;
    assign pos_vld = sof | sync_q;

    // Store the successor position and remember that a marker has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            if (pos_vld) begin
                nxt_q <= (pos == LAST) ? '0 : pos + POS_W'(1);
            end
            sync_q <= pos_vld;
        end
    end

    // Sub-frame 0 has no control bits; its header is covered by FAW_BITS
    assign jc_hit[0] = 1'b0;

    // Justification control bits at the head of each later sub-frame
    for (genvar s = 1; s < N_SUB; s++) begin : g_jc
        localparam int LO = s * SUB_BITS;
        assign jc_hit[s] = (int'(pos) >= LO) && (int'(pos) < LO + JC_BITS);
    end

    // Overhead when inside the frame header or any control-bit group
    assign pos_ovh = (int'(pos) < FAW_BITS) || (|jc_hit);

    // After the last position of a frame, the next position is 0
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_vld && pos == LAST) |=> (pos == '0));

    // Once a marker has been seen, positions stay valid until reset
    assert_sync_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pos_vld |=> pos_vld);

endmodule

// File: rtl/e3rx_ser_path.sv
// Module: serial output stage.
// Registers the bit, the frame-start flag and the overhead flag together, so
// that all three leave in the same cycle. The stage is cleared while it is not
// selected or before the position is valid.
// Assumes: first and ovh describe the same bit as bit_in.
module e3rx_ser_path (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    input  logic vld,
    input  logic first,
    input  logic ovh,
    output logic ser_q,
    output logic strb_q,
    output logic ovh_q
);
    // Register one bit period of output, gated by selection and validity
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ser_q  <= 1'b0;
            strb_q <= 1'b0;
            ovh_q  <= 1'b0;
        end else begin
            ser_q  <= bit_in & vld;
            strb_q <= first & vld;
            ovh_q  <= ovh & vld;
        end
    end

endmodule

// File: rtl/e3rx_nib_pack.sv
// Module: nibble packer.
// Gathers NIB_W consecutive bits, first bit in the MSB, and sends out the word
// with a one-cycle enable after the last bit of each aligned group. It also
// collects frame-start and overhead status over the group.
// Assumes: NIB_W is a power of two, at least 4, and divides the frame length,
// so that the low position bits give the phase within a word.
module e3rx_nib_pack #(
    parameter int NIB_W = e3rx_pkg::E3_NIB_W,
    parameter int PH_W  = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_in,
    input  logic             vld,
    input  logic [PH_W-1:0]  phase,
    input  logic             first,
    input  logic             ovh,
    output logic [NIB_W-1:0] nib_q,
    output logic             nib_en_q,
    output logic             strb_q,
    output logic             ovh_q
);
    logic [NIB_W-2:0] sh_q;
    logic             ovh_acc_q;
    logic             frst_acc_q;
    logic             ovh_any;
    logic             frst_any;
    logic             close;

    // Status so far in the word; a new word starts at phase 0
    assign ovh_any  = ovh   | ((phase != '0) & ovh_acc_q);
    assign frst_any = first | ((phase != '0) & frst_acc_q);
    assign close    = vld & en & (&phase);

    // Shift in bits and keep the status collected for the open word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            ovh_acc_q  <= 1'b0;
            frst_acc_q <= 1'b0;
        end else begin
            sh_q       <= {sh_q[NIB_W-3:0], bit_in};
            ovh_acc_q  <= ovh_any;
            frst_acc_q <= frst_any;
        end
    end

    // Send out the finished word for one cycle, otherwise drive zeros
    always_ff @(posedge clk) begin
        if (!rst_n || !close) begin
            nib_q    <= '0;
            nib_en_q <= 1'b0;
            strb_q   <= 1'b0;
            ovh_q    <= 1'b0;
        end else begin
            nib_q    <= {sh_q, bit_in};
            nib_en_q <= 1'b1;
            strb_q   <= frst_any;
            ovh_q    <= ovh_any;
        end
    end

    // Word enables never occur in back-to-back cycles
    assert_enable_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nib_en_q |=> !nib_en_q);

    // Word strobe and overhead flags appear only with the word enable
    assert_flags_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_q || ovh_q) |-> nib_en_q);

endmodule

// File: rtl/e3rx_payload_out.sv
// Module: E3 receive payload output interface (top).
// Tracks the frame position of each received bit. It drives either the serial
// stage or the nibble packer, chosen by mode_nibble, and merges their outputs.
// The stage that is not selected holds its outputs at zero.
// Assumes: one bit per clock; rx_sof marks the first bit of a frame.
module e3rx_payload_out #(
    parameter int FRAME_BITS = e3rx_pkg::E3_FRAME_BITS,
    parameter int SUB_BITS   = e3rx_pkg::E3_SUB_BITS,
    parameter int FAW_BITS   = e3rx_pkg::E3_FAW_BITS,
    parameter int JC_BITS    = e3rx_pkg::E3_JC_BITS,
    parameter int NIB_W      = e3rx_pkg::E3_NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_sof,
    input  logic             mode_nibble,
    output logic             ser_data,
    output logic             frm_strobe,
    output logic             ovh_flag,
    output logic [NIB_W-1:0] nib_data,
    output logic             nib_en
);
    import e3rx_pkg::*;

    localparam int POS_W = $clog2(FRAME_BITS);
    localparam int PH_W  = $clog2(NIB_W);

    logic [POS_W-1:0] pos;
    logic             pos_vld;
    logic             pos_ovh;
    logic             pos_first;
    logic             ser_sel;
    logic             nib_sel;
    logic             s_strb;
    logic             s_ovh;
    logic             n_strb;
    logic             n_ovh;

    // Decode the mode and frame start
    assign ser_sel   = (e3rx_mode_e'(mode_nibble) == MODE_SERIAL);
    assign nib_sel   = (e3rx_mode_e'(mode_nibble) == MODE_NIBBLE);
    assign pos_first = (pos == '0);

    e3rx_frame_pos #(
        .FRAME_BITS (FRAME_BITS),
        .SUB_BITS   (SUB_BITS),
        .FAW_BITS   (FAW_BITS),
        .JC_BITS    (JC_BITS),
        .POS_W      (POS_W)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (rx_sof),
        .pos     (pos),
        .pos_vld (pos_vld),
        .pos_ovh (pos_ovh)
    );

    e3rx_ser_path u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ser_sel),
        .bit_in (rx_bit),
        .vld    (pos_vld),
        .first  (pos_first),
        .ovh    (pos_ovh),
        .ser_q  (ser_data),
        .strb_q (s_strb),
        .ovh_q  (s_ovh)
    );

    e3rx_nib_pack #(
        .NIB_W (NIB_W),
        .PH_W  (PH_W)
    ) u_nib (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (nib_sel),
        .bit_in   (rx_bit),
        .vld      (pos_vld),
        .phase    (pos[PH_W-1:0]),
        .first    (pos_first),
        .ovh      (pos_ovh),
        .nib_q    (nib_data),
        .nib_en_q (nib_en),
        .strb_q   (n_strb),
        .ovh_q    (n_ovh)
    );

    // The stage not selected is held at zero, so an OR merges the flags
    assign frm_strobe = s_strb | n_strb;
    assign ovh_flag   = s_ovh  | n_ovh;

    // Before the first marker nothing leaves the block
    assert_quiet_until_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pos_vld) |-> (!ser_data && !frm_strobe && !ovh_flag && !nib_en && nib_data == '0));

    // Serial output repeats the previous cycle's input bit once synchronised
    assert_serial_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_nibble) && $past(pos_vld)) |-> (ser_data == $past(rx_bit)));

    // A frame boundary always falls on an overhead position
    assert_strobe_on_overhead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_strobe |-> ovh_flag);

    // Nibble mode silences the serial line
    assert_serial_idle_in_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_nibble) |-> !ser_data);

    // Serial mode silences the word outputs
    assert_word_idle_in_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_nibble) |-> (!nib_en && nib_data == '0));

endmodule

// File: tb/e3rx_payload_out_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes the expected output for every bit
// from its own frame model and queues it; the monitor pops and compares.
module e3rx_payload_out_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 1536;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic       ser;
        logic       strb;
        logic       ovh;
        logic       en;
        logic [3:0] nib;
        logic       mode;
        logic       syn;
        logic       wrap;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_sof = 1'b0;
    logic       mode_nibble = 1'b0;
    logic       ser_data;
    logic       frm_strobe;
    logic       ovh_flag;
    logic [3:0] nib_data;
    logic       nib_en;

    exp_t       q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         m_sync = 0;
    int         m_next = 0;
    logic [2:0] m_hist = '0;
    bit         tb_mode = 0;
    bit         done = 0;

    e3rx_payload_out dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .rx_sof      (rx_sof),
        .mode_nibble (mode_nibble),
        .ser_data    (ser_data),
        .frm_strobe  (frm_strobe),
        .ovh_flag    (ovh_flag),
        .nib_data    (nib_data),
        .nib_en      (nib_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Overhead positions per R4
    function automatic bit ovh_at(input int p);
        return (p < 12) || (p >= 384 && (p % 384) < 4);
    endfunction

    // Driver: present one bit at the falling edge and queue its expected result
    task automatic drive(input logic b, input logic sof, input logic rst_act);
        exp_t e;
        int   p;
        @(negedge clk);
        rst_n       = !rst_act;
        rx_bit      = b;
        rx_sof      = sof;
        mode_nibble = tb_mode;
        e = '0;
        e.mode = tb_mode;
        if (rst_act) begin
            m_sync = 0;
            m_next = 0;
            m_hist = '0;
        end else begin
            if (sof) begin
                p = 0;
                m_sync = 1;
            end else begin
                p = m_next;
            end
            if (m_sync) begin
                e.syn  = 1'b1;
                m_next = (p == FRAME - 1) ? 0 : p + 1;
                if (!tb_mode) begin
                    e.ser  = b;
                    e.strb = (p == 0);
                    e.ovh  = ovh_at(p);
                    e.wrap = (p == 0) && !sof;
                end else if (p % 4 == 3) begin
                    e.en   = 1'b1;
                    e.nib  = {m_hist, b};
                    e.strb = (p == 3);
                    e.ovh  = 1'b0;
                    for (int k = 0; k < 4; k++) e.ovh = e.ovh | ovh_at(p - k);
                end
            end
            m_hist = {m_hist[1:0], b};
        end
        q.push_back(e);
    endtask

    task automatic run_bits(input int n, input bit sof_first);
        for (int i = 0; i < n; i++)
            drive(1'($urandom_range(0, 1)), (i == 0) && sof_first, 1'b0);
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) drive(1'($urandom_range(0, 1)), 1'b0, 1'b1);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Monitor: compare after each rising edge, before the next falling edge
    always begin
        exp_t e;
        string tg;
        @(posedge clk);
        #(CLK_PERIOD*3/10);
        if (q.size() > 0) begin
            e = q.pop_front();
            tg = !e.syn ? "R1" : (e.mode ? "R8" : "R2");
            check(ser_data == e.ser, tg, "ser_data", int'(ser_data), int'(e.ser));
            tg = !e.syn ? "R1" : (e.mode ? "R7" : (e.wrap ? "R5" : "R3"));
            check(frm_strobe == e.strb, tg, "frm_strobe", int'(frm_strobe), int'(e.strb));
            tg = !e.syn ? "R1" : (e.mode ? "R7" : "R4");
            check(ovh_flag == e.ovh, tg, "ovh_flag", int'(ovh_flag), int'(e.ovh));
            tg = !e.syn ? "R1" : (e.mode ? "R6" : "R8");
            check(nib_en == e.en, tg, "nib_en", int'(nib_en), int'(e.en));
            check(nib_data == e.nib, tg, "nib_data", int'(nib_data), int'(e.nib));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset, then bits before any marker stay silent
        tb_mode = 0;
        do_reset(4);
        run_bits(20, 1'b0);
        // R2 R3 R4 R5: serial, two full wraps without marker, then mid-frame restart
        run_bits(2 * FRAME + 700, 1'b1);
        run_bits(FRAME + 10, 1'b1);
        // R6 R7 R8: switch to nibble mode mid-frame
        tb_mode = 1;
        run_bits(1021, 1'b0);
        // marker at an odd offset inside an open word
        run_bits(FRAME + 33, 1'b1);
        // mode flips mid-word and back
        tb_mode = 0;
        run_bits(6, 1'b0);
        tb_mode = 1;
        run_bits(FRAME + 2, 1'b0);
        // R1: reset mid-stream in nibble mode, silent until the next marker
        do_reset(3);
        run_bits(30, 1'b0);
        run_bits(FRAME + 64, 1'b1);
        // back to serial for a final frame
        tb_mode = 0;
        run_bits(FRAME, 1'b1);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule